// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. Bytes are written into a 64-entry, 8-bit transmit queue through a one-cycle write strobe, guarded by a full flag. A serializer takes one byte at a time from the queue and sends it as a frame. The frame has a low start bit, then 5 to 8 data bits sent least significant bit first. An optional even or odd parity bit may follow, and the frame ends with a high stop period of one, one and a half or two bit periods.

Timing is driven by a baud tick input that pulses sixteen times per bit period. Every bit lasts 16 ticks, so a one-and-a-half stop period is exactly 24 ticks. The format inputs are captured when a frame begins, so the software side may set up the next format while a frame is still on the line. When the queue holds more bytes, the frames follow each other with no idle time between them.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd` is 1. A frame begins by driving `txd` to 0 for 16 ticks.
- R2: `cfg_word_len` selects the data width: 0 gives 5 bits, 1 gives 6 bits, 2 gives 7 bits and 3 gives 8 bits. The data bits follow the start bit least significant first, 16 ticks each. Written bits above the selected width are ignored.
- R3: With `cfg_parity_en`=1 and `cfg_parity_odd`=0, a 16-tick parity bit follows the data bits. It is 1 when the sent data bits hold an odd number of ones.
- R4: With `cfg_parity_en`=1 and `cfg_parity_odd`=1, the parity bit is 1 when the sent data bits hold an even number of ones. With `cfg_parity_en`=0, no parity bit is sent.
- R5: `cfg_stop_len` sets the stop period, during which `txd` is 1: code 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks.
- R6: The line changes only on a cycle where `baud_tick` is 1. A frame starts on the first tick on which the queue is non-empty and no frame is in progress. When the queue is non-empty at the last tick of a stop period, the next start bit begins on that tick, leaving a gap of zero ticks.
- R7: The queue holds 64 bytes and sends them in write order. `fifo_full` is 1 when it holds 64 bytes and `fifo_empty` is 1 when it holds none. A write while `fifo_full` is 1 is dropped.
- R8: `tx_busy` is 1 from a frame's start until the end of its last stop tick. The format inputs are captured at frame start, and later changes affect only later frames.
- R9: A write and a frame-start pop in the same cycle both take effect, leaving the byte count unchanged. A write is accepted according to `fifo_full` in that cycle, even if a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe, one byte per cycle |
| wr_byte | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds 64 bytes |
| cfg_word_len | input | 2 | Data width code (0..3 = 5..8 bits) |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop_len | input | 2 | Stop code (0 = 1, 1 = 1.5, 2/3 = 2 bit periods) |
| baud_tick | input | 1 | Pulse at 16 times the bit rate |
| txd | output | 1 | Serial output line, idle high |
| tx_busy | output | 1 | A frame is on the line |
| fifo_empty | output | 1 | Queue holds no bytes |

## Verification
Two functions can fall in the same cycle: a host write into the queue and the serializer's pop at a frame start. The bench holds the baud tick low, loads the queue, and then raises a single tick in the same cycle as a write. It does this once with one byte queued and once with the queue full. It then judges the empty and full flags right after that edge. It also checks that the frames that follow arrive in write order with a zero-tick gap. In the full case, no frame may appear for the dropped byte.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned TX_DATA_W = 8;

    typedef enum logic [1:0] {
        WL_5 = 2'd0,
        WL_6 = 2'd1,
        WL_7 = 2'd2,
        WL_8 = 2'd3
    } word_len_e;

    typedef enum logic [1:0] {
        SB_ONE      = 2'd0,
        SB_ONE_HALF = 2'd1,
        SB_TWO      = 2'd2,
        SB_TWO_ALT  = 2'd3
    } stop_len_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_phase_e;

    typedef struct packed {
        word_len_e wlen;
        logic      par_en;
        logic      par_odd;
        stop_len_e stop;
    } frame_cfg_t;

    function automatic logic [3:0] data_bits(input word_len_e wl);
        case (wl)
            WL_5:    return 4'd5;
            WL_6:    return 4'd6;
            WL_7:    return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [TX_DATA_W-1:0] mask_word(
        input logic [TX_DATA_W-1:0] d,
        input word_len_e            wl
    );
        logic [TX_DATA_W-1:0] m;
        m = '1;
        m = m >> (TX_DATA_W - int'(data_bits(wl)));
        return d & m;
    endfunction

    function automatic logic parity_of(input logic [TX_DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic int stop_ticks(input stop_len_e s, input int os);
        case (s)
            SB_ONE:      return os;
            SB_ONE_HALF: return os + os / 2;
            default:     return 2 * os;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             push;
    logic             pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
            end
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);  // R7
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full);  // R7
    AST_CONCURRENT_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !full && !empty) |=> $stable(count));  // R9

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  frame_cfg_t           cfg_live,
    input  logic                 fifo_empty,
    input  logic [TX_DATA_W-1:0] fifo_data,
    output logic                 pop,
    output logic                 txd,
    output logic                 busy
);
    localparam int STOP_MAX = 2 * OVERSAMPLE;
    localparam int CNT_W    = $clog2(STOP_MAX);
    localparam int IDX_W    = $clog2(TX_DATA_W);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);

    tx_phase_e            phase;
    frame_cfg_t           cfg_q;
    logic [CNT_W-1:0]     cnt;
    logic [IDX_W-1:0]     bit_idx;
    logic [TX_DATA_W-1:0] shreg;
    logic                 par_q;
    logic                 txd_q;
    logic [CNT_W-1:0]     stop_last;
    logic [IDX_W-1:0]     idx_last;
    logic                 stop_done;
    logic [TX_DATA_W-1:0] load_word;

    assign stop_last = CNT_W'(stop_ticks(cfg_q.stop, OVERSAMPLE) - 1);
    assign idx_last  = IDX_W'(data_bits(cfg_q.wlen) - 4'd1);
    assign stop_done = (phase == TX_STOP) && (cnt == stop_last);
    assign pop       = tick && !fifo_empty && ((phase == TX_IDLE) || stop_done);
    assign load_word = mask_word(fifo_data, cfg_live.wlen);
    assign txd       = txd_q;
    assign busy      = (phase != TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= TX_IDLE;
            cfg_q   <= '0;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            txd_q   <= 1'b1;
        end else if (pop) begin
            phase   <= TX_START;
            cfg_q   <= cfg_live;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= load_word;
            par_q   <= parity_of(load_word, cfg_live.par_odd);
            txd_q   <= 1'b0;
        end else if (tick) begin
            case (phase)
                TX_IDLE: begin
                    txd_q <= 1'b1;
                end
                TX_START: begin
                    if (cnt == BIT_LAST) begin
                        cnt     <= '0;
                        phase   <= TX_DATA;
                        bit_idx <= '0;
                        txd_q   <= shreg[0];
                        shreg   <= shreg >> 1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                TX_DATA: begin
                    if (cnt == BIT_LAST) begin
                        cnt <= '0;
                        if (bit_idx == idx_last) begin
                            if (cfg_q.par_en) begin
                                phase <= TX_PARITY;
                                txd_q <= par_q;
                            end else begin
                                phase <= TX_STOP;
                                txd_q <= 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx + IDX_W'(1);
                            txd_q   <= shreg[0];
                            shreg   <= shreg >> 1;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                TX_PARITY: begin
                    if (cnt == BIT_LAST) begin
                        cnt   <= '0;
                        phase <= TX_STOP;
                        txd_q <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                TX_STOP: begin
                    if (cnt == stop_last) begin
                        cnt   <= '0;
                        phase <= TX_IDLE;
                        txd_q <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    phase <= TX_IDLE;
                    txd_q <= 1'b1;
                end
            endcase
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (phase == TX_IDLE) |-> txd_q);  // R1
    AST_START_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        (phase == TX_START) |-> !txd_q);  // R1
    AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (phase == TX_STOP) |-> txd_q);  // R5
    AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(txd_q));  // R6
    AST_START_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
        pop |=> (phase == TX_START) && (cnt == '0));  // R6

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [TX_DATA_W-1:0] wr_byte,
    output logic                 fifo_full,
    input  logic [1:0]           cfg_word_len,
    input  logic                 cfg_parity_en,
    input  logic                 cfg_parity_odd,
    input  logic [1:0]           cfg_stop_len,
    input  logic                 baud_tick,
    output logic                 txd,
    output logic                 tx_busy,
    output logic                 fifo_empty
);
    frame_cfg_t           cfg_live;
    logic [TX_DATA_W-1:0] head_byte;
    logic                 pop;

    assign cfg_live = '{
        wlen:    word_len_e'(cfg_word_len),
        par_en:  cfg_parity_en,
        par_odd: cfg_parity_odd,
        stop:    stop_len_e'(cfg_stop_len)
    };

    uart_tx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (TX_DATA_W)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_valid),
        .wr_data (wr_byte),
        .rd_en   (pop),
        .rd_data (head_byte),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    uart_tx_serializer #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .cfg_live   (cfg_live),
        .fifo_empty (fifo_empty),
        .fifo_data  (head_byte),
        .pop        (pop),
        .txd        (txd),
        .busy       (tx_busy)
    );

    AST_BUSY_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
        !txd |-> tx_busy);  // R8

endmodule

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/1ps
module uart_frame_tx_bench;

    localparam int OS = 16;

    typedef struct {
        logic [255:0] lv;
        int           len;
        string        tag;
        logic [7:0]   data;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       fifo_full;
    logic [1:0] cfg_word_len = 2'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic [1:0] cfg_stop_len = 2'd0;
    logic       baud_tick = 1'b0;
    logic       txd;
    logic       tx_busy;
    logic       fifo_empty;

    int tests = 0;
    int fails = 0;
    bit tick_en = 1'b0;

    frame_t exp_q[$];
    int     gaps_q[$];
    bit     in_frame = 1'b0;
    bit     pend = 1'b0;

    int cw = 3;
    bit cpe = 0;
    bit cpo = 0;
    int csc = 0;

    uart_frame_tx u_uart_frame_tx (
        .clk            (clk),
        .rst            (rst),
        .wr_valid       (wr_valid),
        .wr_byte        (wr_byte),
        .fifo_full      (fifo_full),
        .cfg_word_len   (cfg_word_len),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .cfg_stop_len   (cfg_stop_len),
        .baud_tick      (baud_tick),
        .txd            (txd),
        .tx_busy        (tx_busy),
        .fifo_empty     (fifo_empty)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic frame_t mk(input logic [7:0] d, input int wl, input bit pe,
                                  input bit po, input int sc, input string tag);
        frame_t f;
        int n = 5 + wl;
        logic [7:0] md = d & 8'((1 << n) - 1);
        bit par = po ? ~(^md) : (^md);
        int st = (sc == 0) ? OS : (sc == 1) ? OS + OS / 2 : 2 * OS;
        int p = 0;
        f.lv = '0;
        for (int i = 0; i < OS; i++) begin f.lv[p] = 1'b0; p++; end
        for (int b = 0; b < n; b++)
            for (int i = 0; i < OS; i++) begin f.lv[p] = md[b]; p++; end
        if (pe)
            for (int i = 0; i < OS; i++) begin f.lv[p] = par; p++; end
        for (int i = 0; i < st; i++) begin f.lv[p] = 1'b1; p++; end
        f.len = p;
        f.tag = tag;
        f.data = d;
        return f;
    endfunction

    // tick generator: inputs change 1 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (tick_en) baud_tick = ~baud_tick;
        end
    end

    // monitor: samples the line once per tick, at the falling edge
    initial begin
        frame_t cur;
        int pos = 0;
        int gap = 0;
        int ferr = 0;
        int first_pos = 0;
        int got_b = 0;
        int exp_b = 0;
        forever begin
            @(negedge clk);
            if (rst || !baud_tick) continue;
            if (pend) begin
                pend = 0;
                if (txd == 1'b1 && tx_busy == 1'b1) begin
                    if (ferr == 0) begin first_pos = cur.len; got_b = 1; exp_b = 0; end
                    ferr++;
                end
                tests++;
                if (ferr != 0) begin
                    fails++;
                    $display("FAIL %s frame 0x%02h: %0d mismatches, first at tick %0d got %0d expected %0d",
                             cur.tag, cur.data, ferr, first_pos, got_b, exp_b);
                end
            end
            if (!in_frame) begin
                if (txd == 1'b0) begin
                    in_frame = 1;
                    pos = 0;
                    ferr = 0;
                    gaps_q.push_back(gap);
                    gap = 0;
                    if (exp_q.size() == 0) begin
                        cur.lv = '0;
                        cur.len = OS;
                        cur.tag = "R7 unexpected frame";
                        cur.data = 8'h00;
                        ferr = 1;
                        first_pos = 0; got_b = 1; exp_b = 0;
                    end else begin
                        cur = exp_q.pop_front();
                    end
                end else begin
                    gap++;
                end
            end
            if (in_frame) begin
                if (txd !== cur.lv[pos] || tx_busy !== 1'b1) begin
                    if (ferr == 0) begin
                        first_pos = pos;
                        got_b = int'(txd);
                        exp_b = int'(cur.lv[pos]);
                    end
                    ferr++;
                end
                pos++;
                if (pos == cur.len) begin
                    in_frame = 0;
                    pend = 1;
                end
            end
        end
    end

    task automatic set_cfg(input int wl, input bit pe, input bit po, input int sc);
        @(posedge clk); #1;
        cfg_word_len = 2'(wl);
        cfg_parity_en = pe;
        cfg_parity_odd = po;
        cfg_stop_len = 2'(sc);
        cw = wl; cpe = pe; cpo = po; csc = sc;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(posedge clk); #1;
        wr_valid = 1'b1;
        wr_byte = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        exp_q.push_back(mk(d, cw, cpe, cpo, csc, tag));
        write_byte(d);
    endtask

    task automatic tick_on();
        @(posedge clk); #2;
        tick_en = 1'b1;
    endtask

    task automatic tick_off();
        @(posedge clk); #2;
        tick_en = 1'b0;
        baud_tick = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || in_frame || pend);
        repeat (4) @(negedge clk);
    endtask

    // one manual tick, optionally with a write in the same cycle
    task automatic pulse(input bit with_wr, input logic [7:0] d);
        @(posedge clk); #1;
        baud_tick = 1'b1;
        wr_valid = with_wr;
        wr_byte = d;
        @(posedge clk); #1;
        baud_tick = 1'b0;
        wr_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        chk(txd == 1'b1, "R1", "idle line after reset", int'(txd), 1);
        chk(tx_busy == 1'b0, "R8", "busy after reset", int'(tx_busy), 0);
        chk(fifo_empty == 1'b1, "R7", "empty after reset", int'(fifo_empty), 1);
        chk(fifo_full == 1'b0, "R7", "full after reset", int'(fifo_full), 0);

        tick_on();
        // R2: widths, LSB first, upper bits ignored
        set_cfg(3, 0, 0, 0); send(8'hA5, "R2 8-bit"); wait_idle();
        set_cfg(0, 0, 0, 0); send(8'hE0, "R2 5-bit upper ignored"); wait_idle();
        set_cfg(1, 0, 0, 0); send(8'h96, "R2 6-bit"); wait_idle();
        set_cfg(2, 0, 0, 0); send(8'hC3, "R2 7-bit"); wait_idle();
        // R3: even parity
        set_cfg(3, 1, 0, 0); send(8'h07, "R3 even odd-count"); wait_idle();
        send(8'h03, "R3 even even-count"); wait_idle();
        // R4: odd parity, masking affects parity
        set_cfg(3, 1, 1, 0); send(8'h07, "R4 odd odd-count"); wait_idle();
        set_cfg(2, 1, 1, 0); send(8'h81, "R4 odd 7-bit masked"); wait_idle();
        // R5 / R6: stop lengths with back-to-back frames
        for (int sc = 0; sc < 4; sc++) begin
            set_cfg(1, sc[0], sc[1], sc);
            gaps_q.delete();
            send(8'h2C + 8'(sc), "R5 stop first");
            send(8'h13 + 8'(sc), "R5 stop second");
            wait_idle();
            chk(gaps_q.size() == 2 && gaps_q[1] == 0, "R6", "back-to-back gap ticks",
                (gaps_q.size() == 2) ? gaps_q[1] : -1, 0);
        end

        // R6 / R8: start on first tick, format captured at start
        tick_off();
        set_cfg(3, 1, 0, 0);
        send(8'h5A, "R8 captured format");
        @(posedge clk); #1;
        chk(fifo_empty == 1'b0, "R7", "empty after write", int'(fifo_empty), 0);
        chk(txd == 1'b1, "R6", "no start without tick", int'(txd), 1);
        pulse(1'b0, 8'h00);
        chk(txd == 1'b0, "R6", "start bit after tick", int'(txd), 0);
        chk(tx_busy == 1'b1, "R8", "busy after start", int'(tx_busy), 1);
        chk(fifo_empty == 1'b1, "R7", "empty after pop", int'(fifo_empty), 1);
        set_cfg(0, 0, 0, 2);
        tick_on();
        wait_idle();
        chk(tx_busy == 1'b0, "R8", "busy after frame", int'(tx_busy), 0);

        // R9: write and pop in the same cycle, one byte queued
        tick_off();
        set_cfg(3, 0, 0, 0);
        send(8'h3C, "R9 popped byte");
        exp_q.push_back(mk(8'hC3, cw, cpe, cpo, csc, "R9 concurrent write"));
        gaps_q.delete();
        pulse(1'b1, 8'hC3);
        chk(fifo_empty == 1'b0, "R9", "empty after write+pop", int'(fifo_empty), 0);
        chk(txd == 1'b0, "R9", "start after write+pop", int'(txd), 0);
        tick_on();
        wait_idle();
        chk(gaps_q.size() == 2 && gaps_q[1] == 0, "R9", "concurrent byte follows at once",
            (gaps_q.size() == 2) ? gaps_q[1] : -1, 0);

        // R7 / R9: fill to 64, write while full with a pop in the same cycle
        tick_off();
        for (int i = 0; i < 64; i++) send(8'(i * 7 + 1), "R7 fill order");
        @(posedge clk); #1;
        chk(fifo_full == 1'b1, "R7", "full after 64 writes", int'(fifo_full), 1);
        pulse(1'b1, 8'hEE);
        chk(fifo_full == 1'b0, "R9", "full after dropped write+pop", int'(fifo_full), 0);
        chk(txd == 1'b0, "R9", "start bit while full", int'(txd), 0);
        tick_on();
        wait_idle();
        repeat (80) @(negedge clk);
        chk(fifo_empty == 1'b1, "R7", "empty after drain", int'(fifo_empty), 1);
        chk(txd == 1'b1, "R1", "idle line after drain", int'(txd), 1);
        chk(!in_frame, "R7", "no frame for dropped byte", int'(in_frame), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule